// File: doc/BRIEF.md
# Interlaced Field Timing Generator

This block is the master timing source for interlaced standard-definition video carried as a byte stream. It runs on the pixel-byte clock and keeps two counters: the byte position inside the current line and the line number inside the frame. From these it decodes the horizontal-blank flag (H), the field-identity flag (F) and a vertical-blank flag. H goes out on the horizontal sync pin and F on the vertical sync pin, so an external video source can follow the frame.

The block also outputs the line number, the byte position and two single-cycle requests. These requests mark the first byte of each end-of-active-video code and each start-of-active-video code, so that a companion inserter can place the four-byte embedded codes in the stream. The default frame is 525 lines. A parameter selects the 625-line frame instead, which uses a longer horizontal blank. Line and field changes all take place at the first byte of the end code that opens each line.

The block has no data path, so every port is a plain control or status pin. None of them has a valid/ready handshake and none can apply back-pressure. The counters advance on every clock.

Top module: `sd_field_timer`

## Requirements
- R1: A synchronous reset (`srst` high at a rising edge) sets the byte position to 0 and the line number to 1 on the next cycle.
- R2: The byte position counts 0 up to LINE_BYTES-1 and then returns to 0. LINE_BYTES = 4 + BLANK_BYTES + 4 + ACTIVE_BYTES, which is 1716 by default.
- R3: The line number advances by one when the byte position wraps to 0. After the last line of the frame (525, or 625 in the 625-line mode) it returns to 1. It always stays in the range 1 to the frame line count.
- R4: `hsync_o` (H) is 1 for bytes 0 to 4+BLANK_BYTES+3, which covers the end code, the blank and the start code. It is 0 for the ACTIVE_BYTES bytes that follow.
- R5: In the 525-line mode, `vsync_o` (F) is 0 on lines 4 to 265 and 1 on lines 266 to 525 and 1 to 3.
- R6: In the 525-line mode, `vblank_o` is 1 on lines 1 to 19 and 264 to 282, and 0 on all other lines.
- R7: `eav_req_o` is 1 only on byte 0. `sav_req_o` is 1 only on byte 4+BLANK_BYTES. The two requests are never 1 in the same cycle.
- R8: In the 625-line mode (FRAME_625=1), BLANK_BYTES defaults to 280 and the frame has 625 lines. F is 0 on lines 1 to 312 and 1 on lines 313 to 625. The vertical blank covers lines 1 to 22, 311 to 335 and 624 to 625.
- R9: `line_o`, `vsync_o` and `vblank_o` change only in a cycle where `eav_req_o` is 1. In that cycle `hsync_o` is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-byte clock |
| srst | input | 1 | Synchronous reset, active high |
| hsync_o | output | 1 | H flag: horizontal blank including both codes |
| vsync_o | output | 1 | F flag: field identity |
| vblank_o | output | 1 | Vertical-blank flag |
| line_o | output | LINE_W | Current line number, starting at 1 |
| byte_o | output | BYTE_W | Byte position in the line, starting at 0 |
| eav_req_o | output | 1 | Single-cycle request on the first byte of the end code |
| sav_req_o | output | 1 | Single-cycle request on the first byte of the start code |

## Verification
The block's only input besides the clock is `srst`, so the assertions assume nothing about data. They only need reset to be a clean level that is sampled at the clock edge. After a reset, the counters must start again from byte 0, line 1.

The stimulus drives `srst` only between clock edges. It holds reset off long enough for both frame variants to wrap twice. It then pulses reset at random times, including in the middle of a line, to test how the counters restart. The bench overrides the line length to a short value so that whole frames fit within the run.

// File: rtl/sdtg_pkg.sv
package sdtg_pkg;

  // Width of the four-byte embedded timing codes.
  localparam int unsigned CODE_LEN = 4;

  // Frame line count for each mode.
  function automatic int unsigned frame_lines(input bit pal);
    return pal ? 625 : 525;
  endfunction

  // Default horizontal-blank byte count for each mode.
  function automatic int unsigned blank_len(input bit pal);
    return pal ? 280 : 268;
  endfunction

  // Decoded per-line vertical attributes.
  typedef struct packed {
    logic field;
    logic vblank;
  } sdtg_vattr_t;

  // Decoded per-byte horizontal attributes.
  typedef struct packed {
    logic hblank;
    logic eav;
    logic sav;
  } sdtg_hattr_t;

endpackage

// File: rtl/sdtg_byte_ctr.sv
module sdtg_byte_ctr #(
  parameter int unsigned LINE_BYTES = 1716,
  parameter int unsigned BYTE_W     = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              srst,
  output logic [BYTE_W-1:0] pos_o,
  output logic              last_o
);
  localparam logic [BYTE_W-1:0] LAST_POS = BYTE_W'(LINE_BYTES - 1);

  logic [BYTE_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (srst)                 pos_q <= '0;
    else if (pos_q == LAST_POS) pos_q <= '0;
    else                      pos_q <= pos_q + 1'b1;
  end

  assign pos_o  = pos_q;
  assign last_o = (pos_q == LAST_POS);
endmodule

// File: rtl/sdtg_line_ctr.sv
module sdtg_line_ctr #(
  parameter int unsigned LINES  = 525,
  parameter int unsigned LINE_W = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              step_i,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [LINE_W-1:0] TOP_LINE   = LINE_W'(LINES);
  localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      line_q <= FIRST_LINE;
    end else if (step_i) begin
      if (line_q == TOP_LINE) line_q <= FIRST_LINE;
      else                    line_q <= line_q + 1'b1;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/sdtg_hdecode.sv
module sdtg_hdecode
  import sdtg_pkg::*;
#(
  parameter int unsigned BLANK_BYTES = 268,
  parameter int unsigned BYTE_W      = 11
) (
  input  logic [BYTE_W-1:0] pos_i,
  output sdtg_hattr_t       attr_o
);
  // Start code opens after the end code and the blank interval.
  localparam int unsigned SAV_POS    = CODE_LEN + BLANK_BYTES;
  localparam int unsigned ACTIVE_POS = SAV_POS + CODE_LEN;

  always_comb begin
    attr_o.eav    = (pos_i == '0);
    attr_o.sav    = (pos_i == BYTE_W'(SAV_POS));
    attr_o.hblank = (pos_i < BYTE_W'(ACTIVE_POS));
  end
endmodule

// File: rtl/sdtg_vdecode.sv
module sdtg_vdecode
  import sdtg_pkg::*;
#(
  parameter bit          FRAME_625 = 1'b0,
  parameter int unsigned LINE_W    = 10
) (
  input  logic [LINE_W-1:0] line_i,
  output sdtg_vattr_t       attr_o
);
  generate
    if (FRAME_625) begin : g_625
      // Field 0 occupies the first half; three blank windows.
      localparam int unsigned F1_FROM = 313;
      localparam int unsigned B1_TO   = 22;
      localparam int unsigned B2_FROM = 311;
      localparam int unsigned B2_TO   = 335;
      localparam int unsigned B3_FROM = 624;
      always_comb begin
        attr_o.field  = (line_i >= LINE_W'(F1_FROM));
        attr_o.vblank = (line_i <= LINE_W'(B1_TO))
                     || ((line_i >= LINE_W'(B2_FROM)) && (line_i <= LINE_W'(B2_TO)))
                     || (line_i >= LINE_W'(B3_FROM));
      end
    end else begin : g_525
      // Field 0 spans a window inside the frame; two blank windows.
      localparam int unsigned F0_FROM = 4;
      localparam int unsigned F0_TO   = 265;
      localparam int unsigned B1_TO   = 19;
      localparam int unsigned B2_FROM = 264;
      localparam int unsigned B2_TO   = 282;
      always_comb begin
        attr_o.field  = !((line_i >= LINE_W'(F0_FROM)) && (line_i <= LINE_W'(F0_TO)));
        attr_o.vblank = (line_i <= LINE_W'(B1_TO))
                     || ((line_i >= LINE_W'(B2_FROM)) && (line_i <= LINE_W'(B2_TO)));
      end
    end
  endgenerate
endmodule

// File: rtl/sd_field_timer.sv
module sd_field_timer
  import sdtg_pkg::*;
#(
  parameter bit          FRAME_625    = 1'b0,
  parameter int unsigned ACTIVE_BYTES = 1440,
  parameter int unsigned BLANK_BYTES  = sdtg_pkg::blank_len(FRAME_625),
  parameter int unsigned LINE_BYTES   = 2*sdtg_pkg::CODE_LEN + BLANK_BYTES + ACTIVE_BYTES,
  parameter int unsigned LINES        = sdtg_pkg::frame_lines(FRAME_625),
  parameter int unsigned BYTE_W       = $clog2(LINE_BYTES),
  parameter int unsigned LINE_W       = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              srst,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              vblank_o,
  output logic [LINE_W-1:0] line_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              eav_req_o,
  output logic              sav_req_o
);
  logic [BYTE_W-1:0] pos;
  logic              line_end;
  logic [LINE_W-1:0] line_num;
  sdtg_hattr_t       hattr;
  sdtg_vattr_t       vattr;

  sdtg_byte_ctr #(.LINE_BYTES(LINE_BYTES), .BYTE_W(BYTE_W)) u_byte (
    .clk(clk), .srst(srst), .pos_o(pos), .last_o(line_end)
  );

  sdtg_line_ctr #(.LINES(LINES), .LINE_W(LINE_W)) u_line (
    .clk(clk), .srst(srst), .step_i(line_end), .line_o(line_num)
  );

  sdtg_hdecode #(.BLANK_BYTES(BLANK_BYTES), .BYTE_W(BYTE_W)) u_hdec (
    .pos_i(pos), .attr_o(hattr)
  );

  sdtg_vdecode #(.FRAME_625(FRAME_625), .LINE_W(LINE_W)) u_vdec (
    .line_i(line_num), .attr_o(vattr)
  );

  assign hsync_o   = hattr.hblank;
  assign eav_req_o = hattr.eav;
  assign sav_req_o = hattr.sav;
  assign vsync_o   = vattr.field;
  assign vblank_o  = vattr.vblank;
  assign line_o    = line_num;
  assign byte_o    = pos;
endmodule

// File: rtl/sdtg_checker.sv
module sdtg_checker #(
  parameter int unsigned LINE_BYTES  = 1716,
  parameter int unsigned BLANK_BYTES = 268,
  parameter int unsigned LINES       = 525,
  parameter int unsigned BYTE_W      = 11,
  parameter int unsigned LINE_W      = 10
) (
  input logic              clk,
  input logic              srst,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              vblank_o,
  input logic [LINE_W-1:0] line_o,
  input logic [BYTE_W-1:0] byte_o,
  input logic              eav_req_o,
  input logic              sav_req_o
);
  localparam int unsigned ACT_POS = BLANK_BYTES + 8;

  // R1: the cycle after a reset starts at byte 0 of line 1
  a_r1_restart: assert property (@(posedge clk)
    $past(srst) |-> (byte_o == '0 && line_o == LINE_W'(1)));

  // R2: byte position steps by one except at the line end
  a_r2_byte_step: assert property (@(posedge clk) disable iff (srst)
    (byte_o != BYTE_W'(LINE_BYTES - 1)) |=> (byte_o == $past(byte_o) + 1'b1));

  // R3: line number stays inside the frame
  a_r3_line_range: assert property (@(posedge clk) disable iff (srst)
    (line_o >= LINE_W'(1)) && (line_o <= LINE_W'(LINES)));

  // R4: H falls exactly where active bytes begin
  a_r4_h_fall: assert property (@(posedge clk) disable iff (srst)
    $fell(hsync_o) |-> (byte_o == BYTE_W'(ACT_POS)));

  // R7: the two code requests never coincide
  a_r7_req_excl: assert property (@(posedge clk) disable iff (srst)
    !(eav_req_o && sav_req_o));

  // R9: vertical outputs move only on an end-code byte, with H high
  a_r9_vert_on_eav: assert property (@(posedge clk) disable iff (srst)
    (!$stable(line_o) || !$stable(vsync_o) || !$stable(vblank_o))
      |-> (eav_req_o && hsync_o));
endmodule

bind sd_field_timer sdtg_checker #(
  .LINE_BYTES(LINE_BYTES), .BLANK_BYTES(BLANK_BYTES), .LINES(LINES),
  .BYTE_W(BYTE_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .srst(srst), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .vblank_o(vblank_o), .line_o(line_o), .byte_o(byte_o),
  .eav_req_o(eav_req_o), .sav_req_o(sav_req_o)
);

// File: tb/sd_field_timer_tb.sv
module sd_field_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACT  = 16;
  localparam int BLK  = 8;
  localparam int LB   = ACT + BLK + 8;
  localparam int BW   = $clog2(LB);
  localparam int LW_A = $clog2(526);
  localparam int LW_B = $clog2(626);

  logic clk = 1'b0;
  logic srst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            ha, fa, va, ea, sa;
  logic [LW_A-1:0] la;
  logic [BW-1:0]   ba;
  logic            hb, fb, vb, eb, sb;
  logic [LW_B-1:0] lb;
  logic [BW-1:0]   bb;

  sd_field_timer #(.FRAME_625(1'b0), .ACTIVE_BYTES(ACT), .BLANK_BYTES(BLK)) u_dut (
    .clk(clk), .srst(srst), .hsync_o(ha), .vsync_o(fa), .vblank_o(va),
    .line_o(la), .byte_o(ba), .eav_req_o(ea), .sav_req_o(sa));

  sd_field_timer #(.FRAME_625(1'b1), .ACTIVE_BYTES(ACT), .BLANK_BYTES(BLK)) u_dut_625 (
    .clk(clk), .srst(srst), .hsync_o(hb), .vsync_o(fb), .vblank_o(vb),
    .line_o(lb), .byte_o(bb), .eav_req_o(eb), .sav_req_o(sb));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference position, advanced per the counting rules.
  int mb = 0, ml_a = 1, ml_b = 1;
  bit after_rst = 1'b0;

  always @(posedge clk) begin
    after_rst <= srst;
    if (srst) begin
      mb <= 0; ml_a <= 1; ml_b <= 1;
    end else if (mb == LB-1) begin
      mb   <= 0;
      ml_a <= (ml_a == 525) ? 1 : ml_a + 1;
      ml_b <= (ml_b == 625) ? 1 : ml_b + 1;
    end else begin
      mb <= mb + 1;
    end
  end

  function automatic int exp_h(int b);   return (b < BLK + 8) ? 1 : 0; endfunction
  function automatic int exp_f525(int l); return (l >= 4 && l <= 265) ? 0 : 1; endfunction
  function automatic int exp_v525(int l); return (l <= 19 || (l >= 264 && l <= 282)) ? 1 : 0; endfunction
  function automatic int exp_f625(int l); return (l >= 313) ? 1 : 0; endfunction
  function automatic int exp_v625(int l);
    return (l <= 22 || (l >= 311 && l <= 335) || l >= 624) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d byte %0d)",
               req, what, act, exp, ml_a, mb);
    end
  endtask

  task automatic compare_all();
    if (after_rst) begin
      chk("R1", "byte after reset", int'(ba), 0);
      chk("R1", "line after reset", int'(la), 1);
      chk("R1", "625 line after reset", int'(lb), 1);
    end
    chk("R2", "byte", int'(ba), mb);
    chk("R2", "625 byte", int'(bb), mb);
    chk("R3", "line", int'(la), ml_a);
    chk("R4", "hsync", int'(ha), exp_h(mb));
    chk("R5", "vsync", int'(fa), exp_f525(ml_a));
    chk("R6", "vblank", int'(va), exp_v525(ml_a));
    chk("R7", "eav_req", int'(ea), (mb == 0) ? 1 : 0);
    chk("R7", "sav_req", int'(sa), (mb == BLK + 4) ? 1 : 0);
    chk("R8", "625 line", int'(lb), ml_b);
    chk("R8", "625 vsync", int'(fb), exp_f625(ml_b));
    chk("R8", "625 vblank", int'(vb), exp_v625(ml_b));
    chk("R8", "625 hsync", int'(hb), exp_h(mb));
    // R9: at the opening byte of a line, H and the end-code request coincide
    if (mb == 0) chk("R9", "hsync on eav", int'(ha & ea), 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5D7A1);
    srst = 1'b1;
    repeat (3) @(negedge clk);
    srst = 1'b0;
    // Directed: two full 625-line frames without reset (covers both wraps).
    for (int i = 0; i < 2*625*LB + 200; i++) begin
      @(negedge clk);
      compare_all();
    end
    // Random: reset pulses landing anywhere in the line.
    for (int i = 0; i < 12000; i++) begin
      srst = (($urandom % 300) == 0);
      @(negedge clk);
      compare_all();
    end
    srst = 1'b0;
    // Directed: reset mid-line, then a clean line.
    repeat (7) @(negedge clk);
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    for (int i = 0; i < 3*LB; i++) begin
      @(negedge clk);
      compare_all();
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule